// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block holds the hazard logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). While an instruction sits in decode, the unit compares its two source register numbers with the destinations of the older instructions in execute and memory access. From that comparison it makes one decision. The consumer may take a bypass path, it may wait one cycle behind a load, or it may read the register file as usual. The bypass selects are registered, so they are valid while the consumer is in execute. The store-data select travels one stage further and is valid while the store is in memory access.

The unit also handles control flow. Branches resolve in decode, and fetch carries on down the fall-through path. When a branch is found taken, the unit flushes the single wrong-path instruction held in the fetch/decode register. The register file, the ALU and the caches lie outside the block. The pipeline registers supply the decode, execute and memory-stage fields that the unit reads.

The control path runs through these named situations:
- FLOW: no stall.
- LOAD_WAIT: a load-use stall. The front end holds and a bubble enters execute.
- REDIRECT: a taken branch flushes the fetch/decode register.

A bypass select takes one of three codes: SEL_RF, SEL_EXMEM or SEL_MEMWB.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset, `fwd_a_sel` and `fwd_b_sel` are 0 (SEL_RF, register file) and `st_data_fwd` is 0.
- R2: A load-use stall happens when the execute stage holds a load (`ex_load`=1, `ex_wen`=1) whose nonzero `ex_rd` equals a decode source that is used, either as an ALU operand or address base (any used `id_rs1`) or as an operand (`id_rs2` when `id_store`=0). In that case `hold_front` and `bubble_idex` are 1 in the same cycle. After the next edge, both `fwd_a_sel` and `fwd_b_sel` read 0, because the bubble carries no forwarding.
- R3: A used source that matches a nonzero `ex_rd` with `ex_wen`=1 and `ex_load`=0 causes no stall. After the next edge, that operand's select reads 1 (SEL_EXMEM).
- R4: A used source that matches a nonzero `mem_rd` with `mem_wen`=1, and does not match the execute producer, causes no stall. After the next edge, that operand's select reads 2 (SEL_MEMWB).
- R5: When a source matches both the execute and the memory producer (with the execute one not a load), the younger one wins and the select reads 1.
- R6: A source that is unused, or matches no producer in execute or memory (a distance of three or more), yields select 0 and no stall.
- R7: Register 0 is never a producer. No match on register 0 stalls or forwards.
- R8: A store (`id_store`=1) whose used `id_rs2` (store data) equals a nonzero `ex_rd` of a load does not stall, provided `id_rs1` raises no load-use stall. Two edges later, `st_data_fwd` is 1, and `fwd_b_sel` is 0 after the first edge. In every other case `st_data_fwd` is 0 two edges later.
- R9: `flush_ifid` is 1 exactly when `id_branch`=1, `id_taken`=1 and no load-use stall is raised. While stalled, the redirect waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_AW | Decode source 1 (operand A or address base) |
| id_rs2 | input | REG_AW | Decode source 2 (operand B or store data) |
| id_rs1_used | input | 1 | Source 1 is read |
| id_rs2_used | input | 1 | Source 2 is read |
| id_store | input | 1 | Decode instruction is a store; source 2 is its data |
| id_branch | input | 1 | Decode holds a branch resolved this cycle |
| id_taken | input | 1 | The resolved branch is taken |
| ex_rd | input | REG_AW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage register write enable |
| fwd_a_sel | output | 2 | Operand A bypass select in execute |
| fwd_b_sel | output | 2 | Operand B bypass select in execute |
| st_data_fwd | output | 1 | Store data taken from the memory/write-back result in the memory stage |
| hold_front | output | 1 | Hold PC and fetch/decode register |
| bubble_idex | output | 1 | Insert a bubble into the decode/execute register |
| flush_ifid | output | 1 | Turn the fetch/decode instruction into a NOP |

## Verification
The assertions assume the pipeline feeds the unit consistently. A bubble that the unit requests shows up as a non-writing instruction on the execute fields in the next cycle. Decode fields that are held during a stall reappear unchanged. In a real pipeline these assumptions make the stall last exactly one cycle. The properties here are written only against the current inputs, so they stay valid under any input sequence. The bench drives each input vector once with its own producer fields and then drives a neutral cycle with every write enable low. This sweeps the full source/producer/flag space over registers 0 to 3 and lets both the one-edge selects and the two-edge store-data select be checked in isolation.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/hz_src_decide.sv
module hz_src_decide
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rs,
    input  logic              used,
    input  logic              data_only,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    output fwd_sel_e          sel,
    output logic              load_use,
    output logic              st_fwd
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic ex_hit;
    logic mem_hit;

    // register 0 is never a producer
    assign ex_hit  = used && ex_wen  && (ex_rd  != ZERO_REG) && (ex_rd  == rs);
    assign mem_hit = used && mem_wen && (mem_rd != ZERO_REG) && (mem_rd == rs);

    always_comb begin
        sel      = SEL_RF;
        load_use = 1'b0;
        st_fwd   = 1'b0;
        unique case ({ex_hit, mem_hit})
            2'b10, 2'b11: begin
                if (ex_load) begin
                    if (data_only) st_fwd   = 1'b1;
                    else           load_use = 1'b1;
                end else begin
                    sel = SEL_EXMEM;
                end
            end
            2'b01:   sel = SEL_MEMWB;
            default: sel = SEL_RF;
        endcase
    end
endmodule

// File: rtl/hz_sel_pipe.sv
module hz_sel_pipe
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bubble,
    input  fwd_sel_e a_sel_d,
    input  fwd_sel_e b_sel_d,
    input  logic     st_req_d,
    output fwd_sel_e a_sel_q,
    output fwd_sel_e b_sel_q,
    output logic     st_fwd_q
);
    logic st_ex_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sel_q  <= SEL_RF;
            b_sel_q  <= SEL_RF;
            st_ex_q  <= 1'b0;
            st_fwd_q <= 1'b0;
        end else begin
            if (bubble) begin
                a_sel_q <= SEL_RF;
                b_sel_q <= SEL_RF;
                st_ex_q <= 1'b0;
            end else begin
                a_sel_q <= a_sel_d;
                b_sel_q <= b_sel_d;
                st_ex_q <= st_req_d;
            end
            st_fwd_q <= st_ex_q;
        end
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_rs1_used,
    input  logic              id_rs2_used,
    input  logic              id_store,
    input  logic              id_branch,
    input  logic              id_taken,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              st_data_fwd,
    output logic              hold_front,
    output logic              bubble_idex,
    output logic              flush_ifid
);
    localparam int N_SRC = 2;

    typedef enum logic [1:0] {
        CTL_FLOW      = 2'd0,
        CTL_LOAD_WAIT = 2'd1,
        CTL_REDIRECT  = 2'd2
    } ctl_e;

    logic [REG_AW-1:0] src_reg  [N_SRC];
    logic [N_SRC-1:0]  src_used;
    logic [N_SRC-1:0]  src_data_only;
    fwd_sel_e          src_sel  [N_SRC];
    logic [N_SRC-1:0]  src_lu;
    logic [N_SRC-1:0]  src_st;

    assign src_reg[0]       = id_rs1;
    assign src_reg[1]       = id_rs2;
    assign src_used         = {id_rs2_used, id_rs1_used};
    assign src_data_only    = {id_store, 1'b0};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        hz_src_decide #(.REG_AW(REG_AW)) u_dec (
            .rs        (src_reg[g]),
            .used      (src_used[g]),
            .data_only (src_data_only[g]),
            .ex_rd     (ex_rd),
            .ex_wen    (ex_wen),
            .ex_load   (ex_load),
            .mem_rd    (mem_rd),
            .mem_wen   (mem_wen),
            .sel       (src_sel[g]),
            .load_use  (src_lu[g]),
            .st_fwd    (src_st[g])
        );
    end

    ctl_e ctl;

    always_comb begin
        if (|src_lu)                    ctl = CTL_LOAD_WAIT;
        else if (id_branch && id_taken) ctl = CTL_REDIRECT;
        else                            ctl = CTL_FLOW;
    end

    always_comb begin
        hold_front  = 1'b0;
        bubble_idex = 1'b0;
        flush_ifid  = 1'b0;
        unique case (ctl)
            CTL_LOAD_WAIT: begin
                hold_front  = 1'b1;
                bubble_idex = 1'b1;
            end
            CTL_REDIRECT: flush_ifid = 1'b1;
            default: ;
        endcase
    end

    fwd_sel_e a_q, b_q;

    hz_sel_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble   (bubble_idex),
        .a_sel_d  (src_sel[0]),
        .b_sel_d  (src_sel[1]),
        .st_req_d (|src_st),
        .a_sel_q  (a_q),
        .b_sel_q  (b_q),
        .st_fwd_q (st_data_fwd)
    );

    assign fwd_a_sel = a_q;
    assign fwd_b_sel = b_q;
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_rs1_used,
    input logic              id_rs2_used,
    input logic              id_store,
    input logic              id_branch,
    input logic              id_taken,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_load,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_wen,
    input logic [1:0]        fwd_a_sel,
    input logic [1:0]        fwd_b_sel,
    input logic              st_data_fwd,
    input logic              hold_front,
    input logic              bubble_idex,
    input logic              flush_ifid
);
    a_r2_bubble_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_idex |=> (fwd_a_sel == 2'd0) && (fwd_b_sel == 2'd0));

    a_r3_exmem_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_front && id_rs1_used && ex_wen && !ex_load && ex_rd != '0 && ex_rd == id_rs1)
        |=> fwd_a_sel == 2'd1);

    a_r4_memwb_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_front && id_rs1_used && mem_wen && mem_rd != '0 && mem_rd == id_rs1
         && !(ex_wen && ex_rd == id_rs1))
        |=> fwd_a_sel == 2'd2);

    a_r7_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0 && id_rs2 == '0) |-> !hold_front);

    a_r8_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_front && id_store && id_rs2_used && ex_load && ex_wen
         && ex_rd != '0 && ex_rd == id_rs2) |=> ##1 st_data_fwd);

    a_r9_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ifid |-> (id_branch && id_taken && !hold_front));
endmodule

bind pipe_hazard_unit pipe_hazard_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic id_rs1_used, id_rs2_used, id_store, id_branch, id_taken;
    logic ex_wen, ex_load, mem_wen;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic st_data_fwd, hold_front, bubble_idex, flush_ifid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_unit #(.REG_AW(AW)) u_pipe_hazard_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic neutral();
        id_rs1 = '0; id_rs2 = '0; id_rs1_used = 0; id_rs2_used = 0;
        id_store = 0; id_branch = 0; id_taken = 0;
        ex_rd = '0; ex_wen = 0; ex_load = 0; mem_rd = '0; mem_wen = 0;
    endtask

    // expected select and tag for one source
    task automatic src_exp(input int rs, input bit used, input bit data_only,
                           output int sel, output bit lu, output bit st, output string tag);
        bit exh, memh;
        exh  = used && ex_wen  && ex_rd  != 0 && ex_rd  == rs;
        memh = used && mem_wen && mem_rd != 0 && mem_rd == rs;
        sel = 0; lu = 0; st = 0; tag = "R6";
        if (exh && ex_load) begin
            if (data_only) begin st = 1; tag = "R8"; end
            else begin lu = 1; tag = "R2"; end
        end else if (exh) begin
            sel = 1; tag = memh ? "R5" : "R3";
        end else if (memh) begin
            sel = 2; tag = "R4";
        end else if (used && rs == 0 && ((ex_wen && ex_rd == 0) || (mem_wen && mem_rd == 0))) begin
            tag = "R7";
        end
    endtask

    initial begin
        int sa, sb;
        bit la, lb, xa, xb, stall, stx;
        string ta, tb;
        neutral();
        repeat (3) @(negedge clk);
        chk("R1 fwd_a_sel", fwd_a_sel, 0);
        chk("R1 fwd_b_sel", fwd_b_sel, 0);
        chk("R1 st_data_fwd", st_data_fwd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 16384; v++) begin
            id_rs1      = AW'(v[1:0]);
            id_rs2      = AW'(v[3:2]);
            id_rs1_used = v[4];
            id_rs2_used = v[5];
            id_store    = v[6];
            ex_rd       = AW'(v[8:7]);
            ex_wen      = v[9];
            ex_load     = v[10];
            mem_rd      = AW'(v[12:11]);
            mem_wen     = v[13];
            id_branch   = v[0] ^ v[7];
            id_taken    = v[2] ^ v[11];
            src_exp(int'(id_rs1), id_rs1_used, 1'b0, sa, la, xa, ta);
            src_exp(int'(id_rs2), id_rs2_used, id_store, sb, lb, xb, tb);
            stall = la | lb;
            stx = !stall && (xa | xb);
            #1;
            chk(stall ? "R2 hold_front" : "R7/R6 hold_front", hold_front, stall);
            chk("R2 bubble_idex", bubble_idex, stall);
            chk("R9 flush_ifid", flush_ifid, id_branch && id_taken && !stall);
            @(negedge clk);
            chk(stall ? "R2 fwd_a_sel" : ta, fwd_a_sel, stall ? 0 : sa);
            chk(stall ? "R2 fwd_b_sel" : tb, fwd_b_sel, stall ? 0 : sb);
            neutral();
            @(negedge clk);
            chk("R8 st_data_fwd", st_data_fwd, stx);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule